// File: doc/BRIEF.md
# Stereo Loopback Mix Attenuator

This block sits in a per-sample stereo audio path. On each sample strobe it takes a signed left/right capture pair and a signed left/right playback pair. It scales the capture pair down by a logarithmic attenuation and adds the result to the playback pair. The mixed pair then goes on toward the output converters.

The attenuation is selected by a 6-bit code. Each code step adds 1.5 dB, so code 0 passes the capture sample at unity gain and code 63 reaches the 94.5 dB floor. A separate enable bit acts as a hard mute on the loopback path: when it is clear, the output is an exact copy of the playback input.

The code and the enable are taken together with each sample strobe. A control change made between strobes therefore never splits a sample. The result appears two clock cycles after its strobe, with its own valid pulse.

Top module: `lbmix_atten`

## Requirements
- R1: While reset is asserted, and before the first strobe after reset, `out_valid` is 0 and both output samples are 0.
- R2: Each `in_valid` pulse produces exactly one `out_valid` pulse two clock cycles later. Back-to-back strobes produce back-to-back results.
- R3: With enable set and code 0, each output equals the saturated sum of the playback sample and the unmodified capture sample.
- R4: With enable set and code c, the capture sample x is first arithmetically right-shifted by floor(c/4). It is then multiplied by the gain G[c mod 4], with G = {32768, 27571, 23198, 19519} on a scale of 2^15 (0, 1.5, 3 and 4.5 dB). The product is rounded by adding 2^14 and taking floor division by 2^15. The result is added to the playback sample.
- R5: Every increase of the code by 4 halves the capture contribution (6 dB). For example, code 4 contributes exactly x arithmetically shifted right by one.
- R6: With enable clear, each output equals the playback sample exactly, whatever the capture samples and the code.
- R7: The sum saturates to the signed 16-bit range [-32768, 32767] instead of wrapping.
- R8: Code, enable and sample inputs are used only in the cycle where `in_valid` is 1. Changes to them between strobes do not affect the pending result.
- R9: Between result pulses the output samples hold their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe for all inputs below |
| cap_l | input | 16 | Left capture sample, signed |
| cap_r | input | 16 | Right capture sample, signed |
| play_l | input | 16 | Left playback sample, signed |
| play_r | input | 16 | Right playback sample, signed |
| atten_code | input | 6 | Attenuation code, 1.5 dB per step |
| mix_en | input | 1 | Loopback enable; 0 mutes the capture path |
| out_valid | output | 1 | Result strobe, two cycles after `in_valid` |
| out_l | output | 16 | Left mixed sample, signed |
| out_r | output | 16 | Right mixed sample, signed |

## Verification
The pipeline holds only one sample of state per stage. A wrong captured code, enable or sample therefore corrupts exactly the result that leaves two cycles after its strobe, and nothing after it. The bench scrambles every input immediately after each strobe. Any stage that samples controls at the wrong time then gives a wrong value on the very next output pulse. A broken valid chain or hold path shows up as a misplaced `out_valid`, or as an output that moves in a cycle with no pulse.

// File: rtl/lbmix_pkg.sv
package lbmix_pkg;

   // fractional gain table, unsigned on a 2^15 scale, one entry per 1.5 dB
   localparam int GAIN_W    = 17;
   localparam int FRAC_BITS = 15;
   localparam int SUB_STEPS = 4;

   function automatic logic [GAIN_W-1:0] frac_gain(input logic [1:0] idx);
      logic [GAIN_W-1:0] g;
      case (idx)
         2'd0:    g = 17'd32768;
         2'd1:    g = 17'd27571;
         2'd2:    g = 17'd23198;
         default: g = 17'd19519;
      endcase
      return g;
   endfunction

endpackage

// File: rtl/lbmix_scale.sv
module lbmix_scale
   import lbmix_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CODE_W = 6
) (
   input  logic signed [DATA_W-1:0] sample,
   input  logic        [CODE_W-1:0] code,
   output logic signed [DATA_W-1:0] scaled
);

   localparam int PROD_W = DATA_W + GAIN_W + 1;
   localparam logic signed [PROD_W-1:0] HALF_LSB = PROD_W'(1) <<< (FRAC_BITS - 1);

   logic signed [DATA_W-1:0] shifted;
   logic        [GAIN_W-1:0] gain;
   logic signed [PROD_W-1:0] a_ext;
   logic signed [PROD_W-1:0] b_ext;
   logic signed [PROD_W-1:0] prod;
   logic signed [PROD_W-1:0] rounded;
   logic                     unused_bits;

   // coarse part: 6 dB per shift position
   assign shifted = sample >>> code[CODE_W-1:2];
   // fine part: 1.5 dB sub-steps
   assign gain    = frac_gain(code[1:0]);

   assign a_ext   = PROD_W'(shifted);
   assign b_ext   = $signed({{(PROD_W-GAIN_W){1'b0}}, gain});
   assign prod    = a_ext * b_ext;
   assign rounded = (prod + HALF_LSB) >>> FRAC_BITS;
   assign scaled  = rounded[DATA_W-1:0];

   assign unused_bits = ^rounded[PROD_W-1:DATA_W];

endmodule

// File: rtl/lbmix_satadd.sv
module lbmix_satadd #(
   parameter int DATA_W = 16
) (
   input  logic signed [DATA_W-1:0] a,
   input  logic signed [DATA_W-1:0] b,
   output logic signed [DATA_W-1:0] y
);

   localparam logic signed [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic signed [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

   logic signed [DATA_W:0] wide;
   logic                   ovf;

   assign wide = {a[DATA_W-1], a} + {b[DATA_W-1], b};
   assign ovf  = wide[DATA_W] ^ wide[DATA_W-1];

   always_comb begin
      if (!ovf)             y = wide[DATA_W-1:0];
      else if (wide[DATA_W]) y = MIN_V;
      else                   y = MAX_V;
   end

endmodule

// File: rtl/lbmix_atten.sv
module lbmix_atten
   import lbmix_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CODE_W = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] cap_l,
   input  logic signed [DATA_W-1:0] cap_r,
   input  logic signed [DATA_W-1:0] play_l,
   input  logic signed [DATA_W-1:0] play_r,
   input  logic        [CODE_W-1:0] atten_code,
   input  logic                     mix_en,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_l,
   output logic signed [DATA_W-1:0] out_r
);

   localparam int NCH       = 2;
   localparam int MAX_SHIFT = ((1 << CODE_W) - 1) / SUB_STEPS;

   // elaboration-time parameter checks
   if (DATA_W < 8 || DATA_W > 32) begin : g_bad_width
      $error("lbmix_atten: DATA_W must be 8..32");
   end
   if (CODE_W < 3) begin : g_bad_code
      $error("lbmix_atten: CODE_W must be at least 3");
   end
   if (MAX_SHIFT >= DATA_W) begin : g_bad_depth
      $error("lbmix_atten: coarse shift range exceeds sample width");
   end

   logic [NCH-1:0][DATA_W-1:0] cap_vec;
   logic [NCH-1:0][DATA_W-1:0] play_vec;

   assign cap_vec  = {cap_r, cap_l};
   assign play_vec = {play_r, play_l};

   // stage 1 control: latched only on a sample strobe
   logic              s1_vld;
   logic              s1_en;
   logic [CODE_W-1:0] s1_code;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld  <= 1'b0;
         s1_en   <= 1'b0;
         s1_code <= '0;
      end else begin
         s1_vld <= in_valid;
         if (in_valid) begin
            s1_en   <= mix_en;
            s1_code <= atten_code;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= s1_vld;
   end

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      logic signed [DATA_W-1:0] cap_q;
      logic signed [DATA_W-1:0] play_q;
      logic signed [DATA_W-1:0] scaled;
      logic signed [DATA_W-1:0] addend;
      logic signed [DATA_W-1:0] sum;
      logic signed [DATA_W-1:0] out_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cap_q  <= '0;
            play_q <= '0;
         end else if (in_valid) begin
            cap_q  <= $signed(cap_vec[ch]);
            play_q <= $signed(play_vec[ch]);
         end
      end

      lbmix_scale #(
         .DATA_W (DATA_W),
         .CODE_W (CODE_W)
      ) u_scale (
         .sample (cap_q),
         .code   (s1_code),
         .scaled (scaled)
      );

      // hard mute: nothing of the capture path reaches the adder
      assign addend = s1_en ? scaled : '0;

      lbmix_satadd #(
         .DATA_W (DATA_W)
      ) u_add (
         .a (play_q),
         .b (addend),
         .y (sum)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      out_q <= '0;
         else if (s1_vld) out_q <= sum;
      end
   end

   assign out_l = g_ch[0].out_q;
   assign out_r = g_ch[1].out_q;

endmodule

// File: rtl/lbmix_chk.sv
module lbmix_chk #(
   parameter int DATA_W = 16,
   parameter int CODE_W = 6
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     in_valid,
   input logic signed [DATA_W-1:0] cap_l,
   input logic signed [DATA_W-1:0] cap_r,
   input logic signed [DATA_W-1:0] play_l,
   input logic signed [DATA_W-1:0] play_r,
   input logic        [CODE_W-1:0] atten_code,
   input logic                     mix_en,
   input logic                     out_valid,
   input logic signed [DATA_W-1:0] out_l,
   input logic signed [DATA_W-1:0] out_r
);

   logic [1:0] age;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          age <= 2'd0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   function automatic logic [DATA_W:0] mag(input logic signed [DATA_W-1:0] v);
      logic signed [DATA_W:0] w;
      w = {v[DATA_W-1], v};
      return (w < 0) ? -w : w;
   endfunction

   logic unused_code;
   assign unused_code = ^atten_code;

   AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3) |-> (out_valid == $past(in_valid, 2)));            // R2

   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 2'd0 && !out_valid) |-> ($stable(out_l) && $stable(out_r))); // R9

   AST_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && $past(in_valid, 2) && !$past(mix_en, 2))
      |-> (out_l == $past(play_l, 2) && out_r == $past(play_r, 2)));     // R6

   AST_NO_GAIN_L: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && $past(in_valid, 2) && $past(mix_en, 2) && $past(play_l, 2) == '0)
      |-> (mag(out_l) <= mag($past(cap_l, 2))));                         // R4

   AST_NO_GAIN_R: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && $past(in_valid, 2) && $past(mix_en, 2) && $past(play_r, 2) == '0)
      |-> (mag(out_r) <= mag($past(cap_r, 2))));                         // R4

endmodule

bind lbmix_atten lbmix_chk #(
   .DATA_W (DATA_W),
   .CODE_W (CODE_W)
) i_lbmix_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .cap_l      (cap_l),
   .cap_r      (cap_r),
   .play_l     (play_l),
   .play_r     (play_r),
   .atten_code (atten_code),
   .mix_en     (mix_en),
   .out_valid  (out_valid),
   .out_l      (out_l),
   .out_r      (out_r)
);

// File: tb/test_lbmix_atten.sv
module test_lbmix_atten;

   localparam int CLK_PERIOD = 10;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_valid = 1'b0;
   logic signed [15:0] cap_l = '0, cap_r = '0, play_l = '0, play_r = '0;
   logic        [5:0]  atten_code = '0;
   logic               mix_en = 1'b0;
   logic               out_valid;
   logic signed [15:0] out_l, out_r;

   int total = 0;
   int bad   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lbmix_atten i_lbmix_atten (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .cap_l(cap_l), .cap_r(cap_r), .play_l(play_l), .play_r(play_r),
      .atten_code(atten_code), .mix_en(mix_en),
      .out_valid(out_valid), .out_l(out_l), .out_r(out_r)
   );

   function automatic longint gain_of(input int idx);
      case (idx)
         0: return 32768;
         1: return 27571;
         2: return 23198;
         default: return 19519;
      endcase
   endfunction

   function automatic logic signed [15:0] model(input logic signed [15:0] cap,
                                                input logic signed [15:0] play,
                                                input logic [5:0] code,
                                                input logic en);
      longint sh, p, s;
      if (!en) return play;
      sh = longint'(cap) >>> (int'(code) / 4);
      p  = (sh * gain_of(int'(code) % 4) + 16384) >>> 15;
      s  = longint'(play) + p;
      if (s > 32767)  s = 32767;
      if (s < -32768) s = -32768;
      return 16'(s);
   endfunction

   task automatic chk(input string req, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic scramble();
      cap_l      = 16'($urandom);
      cap_r      = 16'($urandom);
      play_l     = 16'($urandom);
      play_r     = 16'($urandom);
      atten_code = 6'($urandom);
      mix_en     = 1'($urandom);
   endtask

   // one strobe, result checked two edges later, hold checked one edge after
   task automatic send(input logic signed [15:0] cl, input logic signed [15:0] cr,
                       input logic signed [15:0] pl, input logic signed [15:0] pr,
                       input logic [5:0] code, input logic en, input string req);
      logic signed [15:0] el, er;
      el = model(cl, pl, code, en);
      er = model(cr, pr, code, en);
      @(negedge clk);
      cap_l = cl; cap_r = cr; play_l = pl; play_r = pr;
      atten_code = code; mix_en = en; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      scramble();                               // R8: changes between strobes
      chk("R2 early", longint'(out_valid), 0);
      @(negedge clk);
      chk("R2 pulse", longint'(out_valid), 1);
      chk({req, " R8 left"},  longint'(out_l), longint'(el));
      chk({req, " R8 right"}, longint'(out_r), longint'(er));
      @(negedge clk);
      chk("R2 single", longint'(out_valid), 0);
      chk("R9 hold left",  longint'(out_l), longint'(el));
      chk("R9 hold right", longint'(out_r), longint'(er));
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic signed [15:0] e1l, e1r, e2l, e2r;
      void'($urandom(32'd20240611));

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 valid in reset", longint'(out_valid), 0);
      chk("R1 left in reset",  longint'(out_l), 0);
      chk("R1 right in reset", longint'(out_r), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 valid after reset", longint'(out_valid), 0);
      chk("R1 left after reset",  longint'(out_l), 0);

      // R3: unity gain
      send(16'sd1000, -16'sd2000, 16'sd300, 16'sd400, 6'd0, 1'b1, "R3");
      chk("R3 direct left", longint'(out_l), 1300);
      // R5: code 4 halves, code 8 quarters
      send(16'sd1001, -16'sd1001, 16'sd0, 16'sd0, 6'd4, 1'b1, "R5");
      chk("R5 half left", longint'(out_l), 500);
      chk("R5 half right", longint'(out_r), -501);
      send(16'sd4000, -16'sd4000, 16'sd0, 16'sd0, 6'd8, 1'b1, "R5");
      chk("R5 quarter right", longint'(out_r), -1000);
      // R4: sub-steps and floor
      send(16'sd10000, -16'sd10000, 16'sd5, -16'sd5, 6'd1, 1'b1, "R4");
      send(16'sd32767, -16'sd32768, 16'sd0, 16'sd0, 6'd63, 1'b1, "R4");
      send(16'sd12345, 16'sd20000, 16'sd0, 16'sd0, 6'd3, 1'b1, "R4");
      // R6: mute ignores capture and code
      send(16'sd32767, -16'sd32768, -16'sd1234, 16'sd777, 6'd0, 1'b0, "R6");
      chk("R6 mute left", longint'(out_l), -1234);
      // R7: saturation both ways
      send(16'sd30000, -16'sd30000, 16'sd30000, -16'sd30000, 6'd0, 1'b1, "R7");
      chk("R7 top", longint'(out_l), 32767);
      chk("R7 bottom", longint'(out_r), -32768);
      send(16'sd32767, -16'sd32768, 16'sd10000, -16'sd10000, 6'd2, 1'b1, "R7");

      // R2: back-to-back strobes
      e1l = model(16'sd800, 16'sd1, 6'd4, 1'b1);
      e1r = model(-16'sd800, 16'sd2, 6'd4, 1'b1);
      e2l = model(16'sd900, 16'sd3, 6'd0, 1'b0);
      e2r = model(-16'sd900, 16'sd4, 6'd0, 1'b0);
      @(negedge clk);
      cap_l = 16'sd800; cap_r = -16'sd800; play_l = 16'sd1; play_r = 16'sd2;
      atten_code = 6'd4; mix_en = 1'b1; in_valid = 1'b1;
      @(negedge clk);
      cap_l = 16'sd900; cap_r = -16'sd900; play_l = 16'sd3; play_r = 16'sd4;
      atten_code = 6'd0; mix_en = 1'b0;
      @(negedge clk);
      in_valid = 1'b0;
      scramble();
      chk("R2 burst first valid", longint'(out_valid), 1);
      chk("R2 burst first left",  longint'(out_l), longint'(e1l));
      chk("R2 burst first right", longint'(out_r), longint'(e1r));
      @(negedge clk);
      chk("R2 burst second valid", longint'(out_valid), 1);
      chk("R2 burst second left",  longint'(out_l), longint'(e2l));
      chk("R2 burst second right", longint'(out_r), longint'(e2r));
      @(negedge clk);
      chk("R2 burst end", longint'(out_valid), 0);

      // constrained random: codes biased to the ends, extremes sometimes
      for (int n = 0; n < 400; n++) begin
         logic signed [15:0] cl, cr, pl, pr;
         logic [5:0] code;
         logic en;
         int sel;
         sel  = int'($urandom % 8);
         code = (sel == 0) ? 6'd0 : (sel == 1) ? 6'd63 : 6'($urandom);
         en   = ($urandom % 5) != 0;
         cl   = (sel == 2) ? 16'sh7fff : 16'($urandom);
         cr   = (sel == 3) ? 16'sh8000 : 16'($urandom);
         pl   = 16'($urandom);
         pr   = 16'($urandom);
         send(cl, cr, pl, pr, code, en, "R4");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule